// File: doc/BRIEF.md
# Programmable Time Tag Counter

A 16-bit time tag counter for a serial data bus terminal. The counter advances by one on each tick. The tick comes from one of four sources: an internal prescaler that divides the 16 MHz system clock so that one count stands for 2, 4, 8, 16, 32 or 64 µs; the rising edges of an external oscillator; a software step strobe, which is used for self-test; or no source, which holds the count. The host can read the count at any time and can overwrite it.

Two synchronize mode commands act on the counter, each only when its own enable is set. The command without data clears the count. The command with data loads the received 16-bit word. Whenever a message has been processed, a capture strobe latches the current count as the time stamp for that message's descriptor entry. When a tick wraps the count from FFFF to 0000, the block emits a one-cycle rollover event. At 2 µs per count this happens about every 131 ms, and at 64 µs per count about every 4 s.

Top module: `ttag_core`

## Requirements
- R1: After reset, `tag_value` is 0, `stamp_word` is 0, and `stamp_valid` and `wrap_evt` are low.
- R2: With `tick_src` = 0 (internal prescaler), the count advances once every 32·2^k clock cycles, where k is `res_code` (0..5 = 2, 4, 8, 16, 32, 64 µs at 16 MHz). Codes 6 and 7 behave as code 5.
- R3: A cycle with `host_wr` high makes `tag_value` equal `host_wdata` after that edge. This overrides any tick or synchronize command in the same cycle and restarts the prescaler, so the first prescaled tick after the write comes a full period later.
- R4: With `tick_src` = 1, each rising edge of `ext_osc` advances the count by exactly one. The new value appears three clock edges after the edge is first sampled.
- R5: With `tick_src` = 2, each cycle in which `soft_step` is high advances the count by one at that edge. With `tick_src` = 3 the count holds. `soft_step` has no effect when `tick_src` is not 2.
- R6: `sync_plain` with `clr_on_sync` high clears the count at that edge. With `clr_on_sync` low, the command is ignored.
- R7: `sync_word_cmd` with `load_on_sync` high loads `sync_word` into the count at that edge. With `load_on_sync` low, the command is ignored. If both synchronize commands act in the same cycle, the clear wins.
- R8: `wrap_evt` is high for exactly the one cycle after an edge at which a tick took the count from FFFF to 0000. A host write or a synchronize command never raises it.
- R9: A cycle with `msg_capture` high makes `stamp_word` equal the count as it stood before that edge, with `stamp_valid` high for that one following cycle only.
- R10: `tag_value` always shows the present count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the count |
| host_wdata | input | 16 | Value written by the host |
| tag_value | output | 16 | Present count, for host reads |
| res_code | input | 3 | Resolution select (0..5 = 2..64 µs per count) |
| tick_src | input | 2 | 0 prescaler, 1 external oscillator, 2 software step, 3 hold |
| ext_osc | input | 1 | External oscillator, asynchronous |
| soft_step | input | 1 | Software step strobe |
| clr_on_sync | input | 1 | Enables clearing on sync without data |
| load_on_sync | input | 1 | Enables loading on sync with data |
| sync_plain | input | 1 | Synchronize-without-data command strobe |
| sync_word_cmd | input | 1 | Synchronize-with-data command strobe |
| sync_word | input | 16 | Data word of the sync-with-data command |
| msg_capture | input | 1 | Message processed: latch the time stamp |
| stamp_word | output | 16 | Latched time stamp for the descriptor |
| stamp_valid | output | 1 | One-cycle marker of a new stamp |
| wrap_evt | output | 1 | One-cycle rollover event |

## Verification
The hardest case to reach from the ports is a natural rollover. Driven by the prescaler, the wrap would need 65,536 ticks, which is over two million cycles at the finest resolution. The bench instead writes FFFF through the host port and then produces the final tick with a single software step. It also repeats that step while a host write is pending in the same cycle, to show that a forced value never counts as a wrap. The prescaler periods are checked one cycle before and exactly at the expected tick, measured from a host write that restarts the divider.

// File: rtl/ttag_pkg.sv
package ttag_pkg;
  localparam int unsigned TAG_W   = 16;
  localparam int unsigned RES_W   = 3;
  localparam int unsigned RES_MAX = 5;
  localparam int unsigned DIV_MIN = 32;

  typedef enum logic [1:0] {
    SRC_PRESCALE = 2'd0,
    SRC_EXT      = 2'd1,
    SRC_SOFT     = 2'd2,
    SRC_HOLD     = 2'd3
  } tick_src_e;

  // Clock cycles per count for a resolution code; codes past the top clamp.
  function automatic int unsigned ttag_divisor(input logic [RES_W-1:0] code);
    int unsigned k;
    k = (int'(code) > RES_MAX) ? RES_MAX : int'(code);
    return DIV_MIN << k;
  endfunction

  // Value after one tick, with the wrap flag.
  function automatic logic [TAG_W:0] ttag_step(input logic [TAG_W-1:0] v);
    return {1'b0, v} + {{TAG_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/ttag_prescaler.sv
module ttag_prescaler
  import ttag_pkg::*;
#(
  parameter int unsigned DIV_TOP = DIV_MIN << RES_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [RES_W-1:0] res_code,
  output logic             pre_tick
);
  localparam int unsigned PRE_W = $clog2(DIV_TOP);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] term;
  logic             at_term;

  assign term    = PRE_W'(ttag_divisor(res_code) - 1);
  assign at_term = (cnt >= term);
  assign pre_tick = run && !restart && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (at_term)          cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick); // R2
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pre_tick); // R3
endmodule

// File: rtl/ttag_tick_src.sv
module ttag_tick_src
  import ttag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tick_src_e src,
  input  logic      pre_tick,
  input  logic      ext_osc,
  input  logic      soft_step,
  output logic      tick
);
  logic sync_a, sync_b, sync_c;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_c <= 1'b0;
    end else begin
      sync_a <= ext_osc;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign ext_rise = sync_b && !sync_c;

  always_comb begin
    unique case (src)
      SRC_PRESCALE: tick = pre_tick;
      SRC_EXT:      tick = ext_rise;
      SRC_SOFT:     tick = soft_step;
      default:      tick = 1'b0;
    endcase
  end

  AST_EXT_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_HOLD) |-> !tick); // R5
endmodule

// File: rtl/ttag_count.sv
module ttag_count
  import ttag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [TAG_W-1:0] host_wdata,
  input  logic             sync_clr,
  input  logic             sync_ld,
  input  logic [TAG_W-1:0] sync_word,
  input  logic             tick,
  input  logic             capture,
  output logic [TAG_W-1:0] count,
  output logic [TAG_W-1:0] stamp,
  output logic             stamp_valid,
  output logic             wrap
);
  logic [TAG_W:0] stepped;
  logic           forced;

  assign stepped = ttag_step(count);
  assign forced  = host_wr || sync_clr || sync_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= !forced && tick && stepped[TAG_W];
      if (host_wr)       count <= host_wdata;
      else if (sync_clr) count <= '0;
      else if (sync_ld)  count <= sync_word;
      else if (tick)     count <= stepped[TAG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp       <= '0;
      stamp_valid <= 1'b0;
    end else begin
      stamp_valid <= capture;
      if (capture) stamp <= count;
    end
  end

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> count == $past(host_wdata)); // R3
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr && !host_wr) |=> count == '0); // R6
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ld && !sync_clr && !host_wr) |=> count == $past(sync_word)); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !forced) |=> count == $past(count) + 16'd1); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !forced) |=> $stable(count)); // R5
  AST_WRAP_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == '0 && $past(count) == '1)); // R8
  AST_STAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (stamp_valid && stamp == $past(count))); // R9
endmodule

// File: rtl/ttag_core.sv
module ttag_core
  import ttag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [TAG_W-1:0] host_wdata,
  output logic [TAG_W-1:0] tag_value,
  input  logic [RES_W-1:0] res_code,
  input  logic [1:0]       tick_src,
  input  logic             ext_osc,
  input  logic             soft_step,
  input  logic             clr_on_sync,
  input  logic             load_on_sync,
  input  logic             sync_plain,
  input  logic             sync_word_cmd,
  input  logic [TAG_W-1:0] sync_word,
  input  logic             msg_capture,
  output logic [TAG_W-1:0] stamp_word,
  output logic             stamp_valid,
  output logic             wrap_evt
);
  tick_src_e src;
  logic      pre_tick;
  logic      tick;
  logic      sync_clr_go;
  logic      sync_ld_go;

  assign src         = tick_src_e'(tick_src);
  assign sync_clr_go = sync_plain && clr_on_sync;
  assign sync_ld_go  = sync_word_cmd && load_on_sync && !sync_clr_go;

  ttag_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (src == SRC_PRESCALE),
    .restart  (host_wr),
    .res_code (res_code),
    .pre_tick (pre_tick)
  );

  ttag_tick_src u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .pre_tick  (pre_tick),
    .ext_osc   (ext_osc),
    .soft_step (soft_step),
    .tick      (tick)
  );

  ttag_count u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .sync_clr    (sync_clr_go),
    .sync_ld     (sync_ld_go),
    .sync_word   (sync_word),
    .tick        (tick),
    .capture     (msg_capture),
    .count       (tag_value),
    .stamp       (stamp_word),
    .stamp_valid (stamp_valid),
    .wrap        (wrap_evt)
  );

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !wrap_evt); // R8
  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !sync_plain && !sync_word_cmd && src == SRC_HOLD) |=> $stable(tag_value)); // R10
endmodule

// File: tb/ttag_core_tb.sv
module ttag_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] tag_value;
  logic [2:0]  res_code = 0;
  logic [1:0]  tick_src = 2'd3;
  logic        ext_osc = 0, soft_step = 0;
  logic        clr_on_sync = 0, load_on_sync = 0;
  logic        sync_plain = 0, sync_word_cmd = 0;
  logic [15:0] sync_word = 0;
  logic        msg_capture = 0;
  logic [15:0] stamp_word;
  logic        stamp_valid, wrap_evt;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ttag_core u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [15:0] v);
    host_wr = 1; host_wdata = v; step(1); host_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", tag_value, 16'h0);
    chk("R1 stamp", stamp_word, 16'h0);
    chk("R1 valid", {15'b0, stamp_valid}, 16'h0);
    chk("R1 wrap", {15'b0, wrap_evt}, 16'h0);
  endtask

  task automatic t_prescale(input logic [2:0] code, input int div);
    tick_src = 2'd0; res_code = code;
    hwrite(16'h0100);
    step(div - 1);
    chk("R2 before tick", tag_value, 16'h0100);
    step(1);
    chk("R2 at tick", tag_value, 16'h0101);
    step(div);
    chk("R2 second tick", tag_value, 16'h0102);
    tick_src = 2'd3;
  endtask

  task automatic t_write_restart;
    tick_src = 2'd0; res_code = 3'd0;
    hwrite(16'h0000);
    step(20);
    hwrite(16'h0700);
    step(31);
    chk("R3 restart holds", tag_value, 16'h0700);
    step(1);
    chk("R3 restart tick", tag_value, 16'h0701);
    tick_src = 2'd2;
    soft_step = 1; host_wr = 1; host_wdata = 16'hFFFF; step(1);
    host_wr = 0; soft_step = 0;
    chk("R3 write beats tick", tag_value, 16'hFFFF);
    chk("R8 no wrap on write", {15'b0, wrap_evt}, 16'h0);
    clr_on_sync = 1; sync_plain = 1; host_wr = 1; host_wdata = 16'h1234; step(1);
    host_wr = 0; sync_plain = 0; clr_on_sync = 0;
    chk("R3 write beats sync", tag_value, 16'h1234);
    chk("R10 live read", tag_value, 16'h1234);
    tick_src = 2'd3;
  endtask

  task automatic t_ext;
    tick_src = 2'd1;
    hwrite(16'h0010);
    for (int i = 0; i < 3; i++) begin
      ext_osc = 1; step(2);
      chk("R4 latency", tag_value, 16'h0010 + 16'(i));
      step(1);
      chk("R4 edge count", tag_value, 16'h0011 + 16'(i));
      step(3);
      chk("R4 one per edge", tag_value, 16'h0011 + 16'(i));
      ext_osc = 0; step(4);
    end
    tick_src = 2'd3;
  endtask

  task automatic t_soft;
    tick_src = 2'd2;
    hwrite(16'h0020);
    soft_step = 1; step(3); soft_step = 0; step(1);
    chk("R5 soft steps", tag_value, 16'h0023);
    tick_src = 2'd3; soft_step = 1; step(3); soft_step = 0;
    chk("R5 hold ignores step", tag_value, 16'h0023);
    tick_src = 2'd1; soft_step = 1; step(3); soft_step = 0;
    chk("R5 ext ignores step", tag_value, 16'h0023);
    tick_src = 2'd3;
  endtask

  task automatic t_sync;
    hwrite(16'h4321);
    sync_plain = 1; step(1); sync_plain = 0;
    chk("R6 clear disabled", tag_value, 16'h4321);
    clr_on_sync = 1; sync_plain = 1; step(1); sync_plain = 0;
    chk("R6 clear", tag_value, 16'h0000);
    sync_word = 16'hBEEF; sync_word_cmd = 1; step(1); sync_word_cmd = 0;
    chk("R7 load disabled", tag_value, 16'h0000);
    load_on_sync = 1; sync_word_cmd = 1; step(1); sync_word_cmd = 0;
    chk("R7 load", tag_value, 16'hBEEF);
    sync_plain = 1; sync_word_cmd = 1; step(1); sync_plain = 0; sync_word_cmd = 0;
    chk("R7 clear wins", tag_value, 16'h0000);
    hwrite(16'hFFFF);
    sync_word = 16'h0000; sync_word_cmd = 1; step(1); sync_word_cmd = 0;
    chk("R8 no wrap on load", {15'b0, wrap_evt}, 16'h0);
    clr_on_sync = 0; load_on_sync = 0;
  endtask

  task automatic t_wrap;
    tick_src = 2'd2;
    hwrite(16'hFFFE);
    soft_step = 1; step(1); soft_step = 0;
    chk("R8 no wrap early", {15'b0, wrap_evt}, 16'h0);
    soft_step = 1; step(1); soft_step = 0;
    chk("R8 wrapped value", tag_value, 16'h0000);
    chk("R8 wrap high", {15'b0, wrap_evt}, 16'h1);
    step(1);
    chk("R8 wrap one cycle", {15'b0, wrap_evt}, 16'h0);
    tick_src = 2'd3;
  endtask

  task automatic t_capture;
    hwrite(16'h5A5A);
    msg_capture = 1; step(1); msg_capture = 0;
    chk("R9 stamp", stamp_word, 16'h5A5A);
    chk("R9 valid", {15'b0, stamp_valid}, 16'h1);
    tick_src = 2'd2; soft_step = 1; msg_capture = 1; step(1);
    soft_step = 0; msg_capture = 0; tick_src = 2'd3;
    chk("R9 pre-edge value", stamp_word, 16'h5A5A);
    chk("R9 count moved", tag_value, 16'h5A5B);
    step(1);
    chk("R9 valid drops", {15'b0, stamp_valid}, 16'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    step(2);
    t_reset();
    t_prescale(3'd0, 32);
    t_prescale(3'd2, 128);
    t_prescale(3'd5, 1024);
    t_prescale(3'd7, 1024);
    t_write_restart();
    t_ext();
    t_soft();
    t_sync();
    t_wrap();
    t_capture();
    finish_run();
  end
endmodule